// File: doc/BRIEF.md
# Camera Frame Capture Controller

This block sits at the front of a parallel camera port and decides which complete frames reach the downstream datapath. It runs on the system clock. It resynchronises the camera pixel clock, horizontal sync, vertical sync and the 8-bit data bus. It samples them on the pixel clock edge that software selects, and it forwards each accepted byte as a one-cycle strobe with its data.

Software controls the block through a few static fields and a write port for the capture bit:

- **Enable** gates all capture.
- **Mode** selects continuous grab or single-frame snapshot.
- **Rate field** thins the frames in continuous grab.
- **Three polarity bits** set how the pixel clock and both sync pins are read.

Capture always starts at a frame boundary and always stops at one. The capture bit can be read back. It clears itself after a snapshot frame, and also when a deferred stop completes.

Top module: `cam_capture_ctrl`

## Requirements
- R1: While `ctl_enable` is low, `pix_valid` stays low, `frame_active` stays low and no frame is accepted.
- R2: After the capture bit is set, nothing is forwarded until the next frame start. A frame start is a vertical sync change from its invalid level to its valid level, seen at a pixel sampling edge. The frame that is in progress when the bit is set is skipped entirely.
- R3: A byte is forwarded only at a pixel sampling edge where both sync pins are at their valid level inside an accepted frame. `ctl_pclk_pol`=1 samples on the rising edge of `cam_pclk`, and 0 samples on the falling edge.
- R4: `ctl_hs_pol` and `ctl_vs_pol` give the pin level at which data is invalid: 0 means the pin is valid when high, and 1 means it is valid when low.
- R5: With `ctl_snap`=1, exactly one frame is forwarded after capture is set, and `cap_bit` reads 0 once that frame ends.
- R6: A write of 0 to the capture bit while a frame is being forwarded leaves `cap_bit` at 1 and lets that frame finish; `cap_bit` reads 0 after the frame end. The same write with no frame being forwarded clears `cap_bit` at once.
- R7: In continuous mode (`ctl_snap`=0), `ctl_rate` selects which frames are accepted: 0 accepts all frames, 1 accepts frames 0, 2, 4 and so on, and 2 accepts frames 0, 4, 8 and so on, counting from the first frame start after capture is set. The value 3 behaves as 0.
- R8: In snapshot mode, `ctl_rate` has no effect: the first frame after capture is set is the one forwarded.
- R9: The frame-skip count restarts each time capture goes from clear to set, so the first frame after every start is accepted.
- R10: In continuous mode, `cap_bit` stays 1 across frames, and consecutive accepted frames are all forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cam_pclk | input | 1 | Camera pixel clock, oversampled |
| cam_hsync | input | 1 | Horizontal sync pin |
| cam_vsync | input | 1 | Vertical sync pin |
| cam_data | input | DATA_W | Camera data bus |
| ctl_enable | input | 1 | Block enable |
| ctl_snap | input | 1 | 1 = snapshot, 0 = continuous grab |
| ctl_rate | input | 2 | Frame-rate select for continuous grab |
| ctl_pclk_pol | input | 1 | 1 = sample on rising edge, 0 = falling edge |
| ctl_hs_pol | input | 1 | Horizontal sync level meaning invalid |
| ctl_vs_pol | input | 1 | Vertical sync level meaning invalid |
| cap_wr_en | input | 1 | Write strobe for the capture bit |
| cap_wr_val | input | 1 | Value written to the capture bit |
| cap_bit | output | 1 | Capture bit readback |
| frame_active | output | 1 | An accepted frame is being forwarded |
| pix_valid | output | 1 | One-cycle strobe for a forwarded byte |
| pix_data | output | DATA_W | Forwarded byte |

## Verification
A wrong skip count or accept decision shows at the ports within one frame: a whole frame appears or vanishes in the forwarded stream, and the stream is identified by a frame number carried in each byte. A stale stop-pending or capture state shows as a `cap_bit` value that is wrong right after a mid-frame write, or right after the frame end. A sync stage or polarity mistake shows as dropped bytes, out-of-order bytes or gap bytes within the first line.

// File: rtl/cam_capture_pkg.sv
package cam_capture_pkg;

    // Capture mode: continuous grab or single frame
    typedef enum logic {
        CAP_CONT = 1'b0,
        CAP_SNAP = 1'b1
    } cap_mode_e;

    // Rate field encodings
    localparam logic [1:0] RATE_ALL     = 2'd0;
    localparam logic [1:0] RATE_HALF    = 2'd1;
    localparam logic [1:0] RATE_QUARTER = 2'd2;

    // One resynchronised pixel-clock sampling event
    typedef struct packed {
        logic strobe;  // sampling edge of the pixel clock seen this cycle
        logic vs_ok;   // vertical sync at valid level
        logic hs_ok;   // horizontal sync at valid level
        logic sof;     // frame start at this edge
        logic eof;     // frame end at this edge
    } pix_event_t;

    // A pin is valid when it differs from the level that marks invalid data
    function automatic logic pin_valid(input logic pin, input logic inactive_lvl);
        return pin != inactive_lvl;
    endfunction

    // Bits of the skip counter that must be zero for a frame to be accepted
    function automatic logic [1:0] skip_mask(input logic [1:0] rate);
        case (rate)
            RATE_HALF:    return 2'b01;
            RATE_QUARTER: return 2'b11;
            default:      return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/cam_in_sync.sv
module cam_in_sync
    import cam_capture_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pclk_pin,
    input  logic              hs_pin,
    input  logic              vs_pin,
    input  logic [DATA_W-1:0] data_pin,
    input  logic              pclk_pol,
    input  logic              hs_pol,
    input  logic              vs_pol,
    output pix_event_t        ev,
    output logic [DATA_W-1:0] data_out
);
    localparam int W = DATA_W + 3;

    logic [STAGES-1:0][W-1:0] pipe;
    logic                     pclk_prev;
    logic                     vs_ok_prev;
    logic                     pclk_s, hs_s, vs_s;
    logic                     strobe;
    logic                     vs_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= {pclk_pin, hs_pin, vs_pin, data_pin};
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign {pclk_s, hs_s, vs_s, data_out} = pipe[STAGES-1];

    assign strobe = pclk_pol ? (pclk_s && !pclk_prev) : (!pclk_s && pclk_prev);
    assign vs_ok  = pin_valid(vs_s, vs_pol);

    always_ff @(posedge clk) begin
        if (rst) begin
            pclk_prev  <= 1'b0;
            vs_ok_prev <= 1'b0;
        end else begin
            pclk_prev <= pclk_s;
            if (strobe) begin
                vs_ok_prev <= vs_ok;
            end
        end
    end

    always_comb begin
        ev.strobe = strobe;
        ev.vs_ok  = vs_ok;
        ev.hs_ok  = pin_valid(hs_s, hs_pol);
        ev.sof    = strobe && vs_ok && !vs_ok_prev;
        ev.eof    = strobe && !vs_ok && vs_ok_prev;
    end
endmodule

// File: rtl/cam_frame_gate.sv
module cam_frame_gate
    import cam_capture_pkg::*;
#(
    parameter int SKIP_W = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  cap_mode_e  mode,
    input  logic [1:0] rate,
    input  logic       wr_en,
    input  logic       wr_val,
    input  pix_event_t ev,
    output logic       frame_act,
    output logic       cap_bit
);
    logic              cap_q, cap_n;
    logic              pend_q, pend_n;
    logic              act_q, act_n;
    logic [SKIP_W-1:0] skip_q, skip_n;
    logic              wr_clear;
    logic [SKIP_W-1:0] mask;

    assign wr_clear = wr_en && !wr_val;
    assign mask     = SKIP_W'(skip_mask(rate));

    always_comb begin
        cap_n  = cap_q;
        pend_n = pend_q;
        act_n  = act_q;
        skip_n = skip_q;

        // frame end closes the accepted frame and completes any stop
        if (ev.eof && act_q) begin
            act_n = 1'b0;
            if (mode == CAP_SNAP || pend_q) begin
                cap_n = 1'b0;
            end
            pend_n = 1'b0;
        end

        // frame start: decide whether this frame is forwarded
        if (ev.sof && cap_q && !pend_q && !wr_clear && enable) begin
            if (mode == CAP_SNAP) begin
                act_n = 1'b1;
            end else begin
                act_n  = ((skip_q & mask) == '0);
                skip_n = skip_q + 1'b1;
            end
        end

        // software write to the capture bit
        if (wr_en) begin
            if (wr_val) begin
                cap_n  = 1'b1;
                pend_n = 1'b0;
                if (!cap_q) begin
                    skip_n = '0;
                end
            end else if (act_n) begin
                pend_n = 1'b1;
            end else begin
                cap_n  = 1'b0;
                pend_n = 1'b0;
            end
        end

        // disable aborts forwarding and completes a pending stop
        if (!enable) begin
            if (pend_n) begin
                cap_n  = 1'b0;
                pend_n = 1'b0;
            end
            act_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= 1'b0;
            pend_q <= 1'b0;
            act_q  <= 1'b0;
            skip_q <= '0;
        end else begin
            cap_q  <= cap_n;
            pend_q <= pend_n;
            act_q  <= act_n;
            skip_q <= skip_n;
        end
    end

    assign frame_act = act_q;
    assign cap_bit   = cap_q;
endmodule

// File: rtl/cam_pixel_out.sv
module cam_pixel_out
    import cam_capture_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              frame_act,
    input  pix_event_t        ev,
    input  logic [DATA_W-1:0] data_in,
    output logic              valid,
    output logic [DATA_W-1:0] data_out
);
    logic take;

    assign take = ev.strobe && ev.vs_ok && ev.hs_ok && frame_act && enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            data_out <= '0;
        end else begin
            valid <= take;
            if (take) begin
                data_out <= data_in;
            end
        end
    end
endmodule

// File: rtl/cam_capture_ctrl.sv
module cam_capture_ctrl
    import cam_capture_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cam_pclk,
    input  logic              cam_hsync,
    input  logic              cam_vsync,
    input  logic [DATA_W-1:0] cam_data,
    input  logic              ctl_enable,
    input  logic              ctl_snap,
    input  logic [1:0]        ctl_rate,
    input  logic              ctl_pclk_pol,
    input  logic              ctl_hs_pol,
    input  logic              ctl_vs_pol,
    input  logic              cap_wr_en,
    input  logic              cap_wr_val,
    output logic              cap_bit,
    output logic              frame_active,
    output logic              pix_valid,
    output logic [DATA_W-1:0] pix_data
);
    pix_event_t        ev;
    logic [DATA_W-1:0] sync_data;
    cap_mode_e         mode;

    assign mode = ctl_snap ? CAP_SNAP : CAP_CONT;

    cam_in_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .pclk_pin (cam_pclk),
        .hs_pin   (cam_hsync),
        .vs_pin   (cam_vsync),
        .data_pin (cam_data),
        .pclk_pol (ctl_pclk_pol),
        .hs_pol   (ctl_hs_pol),
        .vs_pol   (ctl_vs_pol),
        .ev       (ev),
        .data_out (sync_data)
    );

    cam_frame_gate #(.SKIP_W(2)) gate_i (
        .clk       (clk),
        .rst       (rst),
        .enable    (ctl_enable),
        .mode      (mode),
        .rate      (ctl_rate),
        .wr_en     (cap_wr_en),
        .wr_val    (cap_wr_val),
        .ev        (ev),
        .frame_act (frame_active),
        .cap_bit   (cap_bit)
    );

    cam_pixel_out #(.DATA_W(DATA_W)) out_i (
        .clk       (clk),
        .rst       (rst),
        .enable    (ctl_enable),
        .frame_act (frame_active),
        .ev        (ev),
        .data_in   (sync_data),
        .valid     (pix_valid),
        .data_out  (pix_data)
    );
endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk (
    input logic clk,
    input logic rst,
    input logic ctl_enable,
    input logic ctl_snap,
    input logic cap_wr_en,
    input logic cap_bit,
    input logic frame_active,
    input logic pix_valid
);
    // R3
    byte_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(frame_active));

    // R1
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_enable |=> !pix_valid);

    // R2
    start_needs_capture_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_active) |-> $past(cap_bit));

    // R6
    stop_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cap_bit) |-> !frame_active);

    // R5
    snap_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(frame_active) && $past(ctl_enable) && $past(ctl_snap) && !$past(cap_wr_en))
        |-> !cap_bit);
endmodule

bind cam_capture_ctrl cam_capture_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .ctl_enable   (ctl_enable),
    .ctl_snap     (ctl_snap),
    .cap_wr_en    (cap_wr_en),
    .cap_bit      (cap_bit),
    .frame_active (frame_active),
    .pix_valid    (pix_valid)
);

// File: tb/cam_capture_ctrl_tb.sv
module cam_capture_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam logic [7:0] GAP = 8'hEE;

    typedef struct packed {
        logic       snap;
        logic [1:0] rate;
        logic       pp;
        logic       ph;
        logic       pv;
        logic [3:0] nf;
        logic [7:0] mask;
        logic       cap_end;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{snap:1'b0, rate:2'd0, pp:1'b1, ph:1'b0, pv:1'b0, nf:4'd3, mask:8'h07, cap_end:1'b1},
        '{snap:1'b0, rate:2'd1, pp:1'b0, ph:1'b1, pv:1'b1, nf:4'd4, mask:8'h05, cap_end:1'b1},
        '{snap:1'b0, rate:2'd2, pp:1'b1, ph:1'b1, pv:1'b0, nf:4'd6, mask:8'h11, cap_end:1'b1},
        '{snap:1'b0, rate:2'd2, pp:1'b1, ph:1'b0, pv:1'b1, nf:4'd1, mask:8'h01, cap_end:1'b1},
        '{snap:1'b1, rate:2'd0, pp:1'b0, ph:1'b0, pv:1'b0, nf:4'd3, mask:8'h01, cap_end:1'b0},
        '{snap:1'b1, rate:2'd2, pp:1'b1, ph:1'b0, pv:1'b0, nf:4'd3, mask:8'h01, cap_end:1'b0},
        '{snap:1'b0, rate:2'd3, pp:1'b1, ph:1'b0, pv:1'b0, nf:4'd2, mask:8'h03, cap_end:1'b1}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R10/R4 all frames";
            1: return "R7/R4 half rate, falling edge";
            2: return "R7 quarter rate";
            3: return "R9 skip restart";
            4: return "R5 snapshot";
            5: return "R8 snapshot ignores rate";
            default: return "R7 rate 3 as all";
        endcase
    endfunction

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cam_pclk = 1'b0, cam_hsync = 1'b0, cam_vsync = 1'b0;
    logic [DW-1:0] cam_data = '0;
    logic          ctl_enable = 1'b1, ctl_snap = 1'b0;
    logic [1:0]    ctl_rate = 2'd0;
    logic          ctl_pclk_pol = 1'b1, ctl_hs_pol = 1'b0, ctl_vs_pol = 1'b0;
    logic          cap_wr_en = 1'b0, cap_wr_val = 1'b0;
    logic          cap_bit, frame_active, pix_valid;
    logic [DW-1:0] pix_data;

    int checks = 0;
    int failures = 0;
    int rx_bytes = 0, rx_bad = 0, rx_order_bad = 0;
    logic [15:0] rx_mask = '0;
    logic saw_active = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cam_capture_ctrl #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst),
        .cam_pclk(cam_pclk), .cam_hsync(cam_hsync), .cam_vsync(cam_vsync), .cam_data(cam_data),
        .ctl_enable(ctl_enable), .ctl_snap(ctl_snap), .ctl_rate(ctl_rate),
        .ctl_pclk_pol(ctl_pclk_pol), .ctl_hs_pol(ctl_hs_pol), .ctl_vs_pol(ctl_vs_pol),
        .cap_wr_en(cap_wr_en), .cap_wr_val(cap_wr_val),
        .cap_bit(cap_bit), .frame_active(frame_active),
        .pix_valid(pix_valid), .pix_data(pix_data)
    );

    // stream monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (frame_active) saw_active <= 1'b1;
        if (pix_valid) begin
            if (pix_data == GAP) begin
                rx_bad <= rx_bad + 1;
            end else begin
                rx_mask[pix_data[7:4]] <= 1'b1;
                if (pix_data[2:0] != 3'(rx_bytes % 8)) rx_order_bad <= rx_order_bad + 1;
            end
            rx_bytes <= rx_bytes + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_rx();
        @(negedge clk);
        rx_bytes = 0; rx_bad = 0; rx_order_bad = 0; rx_mask = '0; saw_active = 1'b0;
    endtask

    task automatic wr_cap(input logic v);
        @(negedge clk);
        cap_wr_en = 1'b1; cap_wr_val = v;
        @(negedge clk);
        cap_wr_en = 1'b0;
    endtask

    // one pixel clock period: change away from the sampling edge, then sample
    task automatic pix(input logic hs_v, input logic vs_v, input logic [7:0] d);
        @(negedge clk);
        cam_hsync = hs_v ? ~ctl_hs_pol : ctl_hs_pol;
        cam_vsync = vs_v ? ~ctl_vs_pol : ctl_vs_pol;
        cam_data  = d;
        cam_pclk  = ~ctl_pclk_pol;
        repeat (4) @(negedge clk);
        cam_pclk  = ctl_pclk_pol;
        repeat (4) @(negedge clk);
    endtask

    // act: 0 none, 1 set capture after frame start, 2 clear capture after frame start
    task automatic frame(input int id, input int act);
        pix(1'b0, 1'b0, GAP); pix(1'b0, 1'b0, GAP);
        pix(1'b0, 1'b1, GAP); pix(1'b0, 1'b1, GAP);
        if (act == 1) wr_cap(1'b1);
        if (act == 2) begin
            wr_cap(1'b0);
            @(negedge clk);
            chk(cap_bit == 1'b1, "R6 cap_bit held during frame", int'(cap_bit), 1);
        end
        for (int ln = 0; ln < 2; ln++) begin
            for (int k = 0; k < 4; k++) begin
                pix(1'b1, 1'b1, 8'(id * 16 + ln * 4 + k));
            end
            pix(1'b0, 1'b1, GAP);
        end
        pix(1'b0, 1'b0, GAP); pix(1'b0, 1'b0, GAP);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pix_valid == 1'b0, "R1 reset pix_valid", int'(pix_valid), 0);
        chk(frame_active == 1'b0, "R1 reset frame_active", int'(frame_active), 0);
        chk(cap_bit == 1'b0, "R5 reset cap_bit", int'(cap_bit), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            ctl_snap = VECS[i].snap; ctl_rate = VECS[i].rate;
            ctl_pclk_pol = VECS[i].pp; ctl_hs_pol = VECS[i].ph; ctl_vs_pol = VECS[i].pv;
            pix(1'b0, 1'b0, GAP);
            clr_rx();
            wr_cap(1'b1);
            for (int f = 0; f < int'(VECS[i].nf); f++) frame(f, 0);
            repeat (4) @(negedge clk);
            chk(rx_mask == 16'(VECS[i].mask), vec_tag(i), int'(rx_mask), int'(VECS[i].mask));
            chk(rx_bytes == 8 * $countones(VECS[i].mask), vec_tag(i), rx_bytes,
                8 * $countones(VECS[i].mask));
            chk(rx_bad == 0 && rx_order_bad == 0, "R3 only valid bytes in order",
                rx_bad + rx_order_bad, 0);
            chk(cap_bit == VECS[i].cap_end, vec_tag(i), int'(cap_bit), int'(VECS[i].cap_end));
            wr_cap(1'b0);
            @(negedge clk);
            chk(cap_bit == 1'b0, "R6 idle clear is immediate", int'(cap_bit), 0);
        end

        // R2: capture set mid-frame waits for the next frame start
        ctl_snap = 1'b0; ctl_rate = 2'd0; ctl_pclk_pol = 1'b1; ctl_hs_pol = 1'b0; ctl_vs_pol = 1'b0;
        pix(1'b0, 1'b0, GAP);
        clr_rx();
        frame(0, 1);
        frame(1, 0);
        repeat (4) @(negedge clk);
        chk(rx_mask == 16'h0002, "R2 mid-frame set skips current frame", int'(rx_mask), 2);
        chk(rx_bytes == 8, "R2 byte count", rx_bytes, 8);

        // R6: clear during a forwarded frame completes it, then stops
        clr_rx();
        frame(0, 2);
        repeat (4) @(negedge clk);
        chk(cap_bit == 1'b0, "R6 cleared after frame end", int'(cap_bit), 0);
        chk(rx_bytes == 8, "R6 frame finished", rx_bytes, 8);
        frame(1, 0);
        repeat (4) @(negedge clk);
        chk(rx_mask == 16'h0001, "R6 no frame after stop", int'(rx_mask), 1);

        // R1: enable low blocks everything
        ctl_enable = 1'b0;
        clr_rx();
        wr_cap(1'b1);
        frame(0, 0);
        frame(1, 0);
        repeat (4) @(negedge clk);
        chk(rx_bytes == 0, "R1 no bytes while disabled", rx_bytes, 0);
        chk(saw_active == 1'b0, "R1 no frame while disabled", int'(saw_active), 0);
        ctl_enable = 1'b1;
        frame(2, 0);
        repeat (4) @(negedge clk);
        chk(rx_mask == 16'h0004, "R1 capture resumes after enable", int'(rx_mask), 4);
        wr_cap(1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule